// File: doc/BRIEF.md
# Tuning Synthesizer Control Receiver

This block is a write-only two-wire bus slave. It loads the control word of a radio-tuning frequency synthesizer. A faster system clock oversamples the bus clock and data lines. The block finds START and STOP conditions and shifts in bytes on the rising edges of the bus clock. It pulls the data line low in the ninth clock slot to acknowledge each byte it accepts.

A transfer has three parts: a device address, then a subaddress, then data bytes. The subaddress selects one of two fixed byte sequences:

- **Reference sequence:** a mode byte, then the 16-bit reference divider, high byte first.
- **Feedback sequence:** the 16-bit feedback divider, high byte first.

The three registers drive the divider and phase-detector logic that sit next to this block. One address bit is compared with a strap pin, so two of these receivers can share one bus.

Top module: `tune_ctl_i2c_slave`

## Requirements
- R1: After reset, `mode_q`, `ref_div_q` and `fb_div_q` are zero and `sda_oe_o` is low.
- R2: The block acknowledges an address byte only when all of the following hold:
  - bits 7..2 are 110010;
  - bit 1 equals `addr_sel_i`;
  - bit 0 (the read flag) is 0.
- R3: The block does not acknowledge an address byte with the wrong pattern, the wrong strap bit, or bit 0 = 1. After such a byte it acknowledges nothing and changes no register until the next START.
- R4: A subaddress whose bits 4..2 are 001 (other bits ignored) starts the reference sequence. The first data byte goes to `mode_q`. The next two data bytes are the high and low bytes of `ref_div_q`.
- R5: A subaddress whose bits 3..2 are 11 and which does not match R4 (other bits ignored) starts the feedback sequence. The two data bytes are the high and low bytes of `fb_div_q`.
- R6: `mode_q` holds its data byte bit for bit. The fields are:
  - bit 7: switching output;
  - bit 6: band select;
  - bit 5: phase-detector analogue/test;
  - bit 4: phase-detector polarity;
  - bit 3: charge-pump current select.
- R7: A subaddress that matches neither pattern is acknowledged. The block acknowledges the data bytes that follow but stores none of them.
- R8: A data byte sent after the last byte of its sequence is not acknowledged and changes no register.
- R9: A divider output changes only when its low byte is accepted. A STOP after the high byte leaves the old value in place.
- R10: A repeated START in the middle of a transfer begins a new address phase. The half-received divider is discarded.
- R11: `sda_oe_o` changes only while the bus clock is low. It is high for exactly the acknowledge slot of an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap pin compared with address bit 1 |
| sda_oe_o | output | 1 | When high, pull the data line low |
| mode_q | output | 8 | Mode byte from the reference sequence |
| ref_div_q | output | 16 | Reference divider value |
| fb_div_q | output | 16 | Feedback divider value |

## Verification
A wrong sequence pointer or phase shows up at the ports in one of two ways:
- the acknowledge slot of the very next byte, which goes missing or appears where it should not;
- a register that takes the wrong byte as soon as that byte's acknowledge begins.

A wrong commit of a divider is seen on the output register at the ninth falling clock edge of a cut-short or overlong transfer. The checks after STOP read the registers directly, so a stale or early commit is caught within the same transfer.

// File: rtl/tune_ctl_i2c_slave.sv
module tune_ctl_i2c_slave #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_ID      = 6'b110010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        addr_sel_i,
  output logic        sda_oe_o,
  output logic [7:0]  mode_q,
  output logic [15:0] ref_div_q,
  output logic [15:0] fb_div_q
);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK} state_t;
  typedef enum logic [1:0] {P_ADDR, P_SUB, P_DATA} phase_t;
  typedef enum logic [1:0] {Q_NONE, Q_REF, Q_FB} seq_t;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  wire scl_s    = scl_sync[SYNC_STAGES-1];
  wire sda_s    = sda_sync[SYNC_STAGES-1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  state_t     state;
  phase_t     phase;
  seq_t       seq;
  logic [1:0] idx;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] hi_hold;
  logic       ack_ok;

  always_comb begin
    ack_ok = 1'b0;
    case (phase)
      P_ADDR: ack_ok = (shreg[7:2] == DEV_ID) && (shreg[1] == addr_sel_i) && !shreg[0];
      P_SUB:  ack_ok = 1'b1;
      P_DATA: begin
        case (seq)
          Q_REF:   ack_ok = (idx <= 2'd2);
          Q_FB:    ack_ok = (idx <= 2'd1);
          default: ack_ok = 1'b1;
        endcase
      end
      default: ack_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= P_ADDR;
      seq       <= Q_NONE;
      idx       <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      hi_hold   <= '0;
      sda_oe_o  <= 1'b0;
      mode_q    <= '0;
      ref_div_q <= '0;
      fb_div_q  <= '0;
    end else if (start_c) begin
      state    <= S_RX;
      phase    <= P_ADDR;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      state    <= S_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            if (!ack_ok) begin
              state <= S_IDLE;
            end else begin
              state    <= S_ACK;
              sda_oe_o <= 1'b1;
              if (phase == P_SUB) begin
                idx <= '0;
                if (shreg[4:2] == 3'b001)     seq <= Q_REF;
                else if (shreg[3:2] == 2'b11) seq <= Q_FB;
                else                          seq <= Q_NONE;
              end else if (phase == P_DATA && seq != Q_NONE) begin
                idx <= idx + 2'd1;
                if (seq == Q_REF) begin
                  case (idx)
                    2'd0:    mode_q    <= shreg;
                    2'd1:    hi_hold   <= shreg;
                    default: ref_div_q <= {hi_hold, shreg};
                  endcase
                end else begin
                  if (idx == 2'd0) hi_hold  <= shreg;
                  else             fb_div_q <= {hi_hold, shreg};
                end
              end
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            sda_oe_o <= 1'b0;
            bit_cnt  <= '0;
            state    <= S_RX;
            if (phase == P_ADDR)     phase <= P_SUB;
            else if (phase == P_SUB) phase <= P_DATA;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

module tune_ctl_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic [7:0]  mode_q,
  input logic [15:0] ref_div_q,
  input logic [15:0] fb_div_q
);

  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe_o && mode_q == 8'h00 && ref_div_q == 16'h0 && fb_div_q == 16'h0));

  a_r4_mode_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $rose(sda_oe_o));

  a_r9_ref_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_div_q) |-> $rose(sda_oe_o));

  a_r5_fb_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_div_q) |-> $rose(sda_oe_o));

  a_r11_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

endmodule

bind tune_ctl_i2c_slave tune_ctl_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .mode_q(mode_q), .ref_div_q(ref_div_q), .fb_div_q(fb_div_q)
);

// File: tb/tune_ctl_i2c_slave_bench.sv
module tune_ctl_i2c_slave_bench;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, as_pin = 1'b0;
  logic sda_oe;
  logic [7:0] mode_q;
  logic [15:0] ref_q, fb_q;
  wire line = m_sda & ~sda_oe;
  int runs = 0, fails = 0;

  always #5 clk = ~clk;

  tune_ctl_i2c_slave u_tune_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(line), .addr_sel_i(as_pin),
    .sda_oe_o(sda_oe), .mode_q(mode_q), .ref_div_q(ref_q), .fb_div_q(fb_q));

  typedef struct packed {
    logic            as;
    logic [7:0]      adr;
    logic [7:0]      sub;
    logic [2:0]      nd;
    logic [0:3][7:0] d;
    logic [5:0]      ackm;
    logic [7:0]      st;
    logic [15:0]     rf;
    logic [15:0]     fb;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'hC8, 8'h04, 3'd3, 32'hA5123400, 6'b011111, 8'hA5, 16'h1234, 16'h0000},
    '{1'b0, 8'hC8, 8'h0C, 3'd2, 32'h56780000, 6'b001111, 8'hA5, 16'h1234, 16'h5678},
    '{1'b1, 8'hCA, 8'hFC, 3'd2, 32'h9ABC0000, 6'b001111, 8'hA5, 16'h1234, 16'h9ABC},
    '{1'b1, 8'hC8, 8'h04, 3'd3, 32'h11223300, 6'b000000, 8'hA5, 16'h1234, 16'h9ABC},
    '{1'b0, 8'hC9, 8'h04, 3'd3, 32'h11223300, 6'b000000, 8'hA5, 16'h1234, 16'h9ABC},
    '{1'b0, 8'hC8, 8'h00, 3'd2, 32'h11220000, 6'b001111, 8'hA5, 16'h1234, 16'h9ABC},
    '{1'b0, 8'hC8, 8'h04, 3'd4, 32'h3CABCDEE, 6'b011111, 8'h3C, 16'hABCD, 16'h9ABC},
    '{1'b0, 8'hC8, 8'h0C, 3'd3, 32'h01020300, 6'b001111, 8'h3C, 16'hABCD, 16'h0102},
    '{1'b0, 8'hC8, 8'hE7, 3'd3, 32'h5A000100, 6'b011111, 8'h5A, 16'h0001, 16'h0102}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R4/R6";
      1: return "R5";
      2: return "R2";
      3: return "R3";
      4: return "R3";
      5: return "R7";
      6: return "R8";
      7: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(H);
  endtask

  task automatic bus_restart();
    wt(H/2); m_sda = 1'b1; wt(H/2);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    wt(H/2); m_sda = 1'b0; wt(H/2);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wt(H/2); m_sda = b[i]; wt(H/2);
      m_scl = 1'b1; wt(H);
      m_scl = 1'b0;
    end
    wt(H/2); m_sda = 1'b1; wt(H/2);
    m_scl = 1'b1; wt(H/2);
    ack = (line == 1'b0);
    wt(H/2); m_scl = 1'b0;
  endtask

  logic a;
  logic [5:0] am;

  initial begin
    wt(5);
    check("R1 oe", {31'd0, sda_oe}, 32'd0);
    check("R1 mode", {24'd0, mode_q}, 32'd0);
    check("R1 ref", {16'd0, ref_q}, 32'd0);
    check("R1 fb", {16'd0, fb_q}, 32'd0);
    rst_n = 1'b1;
    wt(5);

    for (int v = 0; v < NV; v++) begin
      as_pin = VEC[v].as;
      wt(4);
      am = '0;
      bus_start();
      send_byte(VEC[v].adr, a); am[0] = a;
      send_byte(VEC[v].sub, a); am[1] = a;
      for (int k = 0; k < 4; k++)
        if (k < int'(VEC[v].nd)) begin
          send_byte(VEC[v].d[k], a); am[2+k] = a;
        end
      bus_stop();
      check({vtag(v), " ack"}, {26'd0, am}, {26'd0, VEC[v].ackm});
      check({vtag(v), " mode"}, {24'd0, mode_q}, {24'd0, VEC[v].st});
      check({vtag(v), " ref"}, {16'd0, ref_q}, {16'd0, VEC[v].rf});
      check({vtag(v), " fb"}, {16'd0, fb_q}, {16'd0, VEC[v].fb});
    end

    // R9: STOP after high byte of the reference divider
    bus_start();
    send_byte(8'hC8, a); send_byte(8'h04, a);
    send_byte(8'h77, a); send_byte(8'hFF, a);
    bus_stop();
    check("R9 mode stored", {24'd0, mode_q}, 32'h77);
    check("R9 ref kept", {16'd0, ref_q}, 32'h0001);

    // R9: STOP after high byte of the feedback divider
    bus_start();
    send_byte(8'hC8, a); send_byte(8'h0C, a); send_byte(8'h44, a);
    bus_stop();
    check("R9 fb kept", {16'd0, fb_q}, 32'h0102);

    // R10: repeated START drops the half-written divider
    am = '0;
    bus_start();
    send_byte(8'hC8, a); send_byte(8'h0C, a); send_byte(8'hAA, a);
    bus_restart();
    send_byte(8'hC8, a); am[0] = a;
    send_byte(8'h0C, a); am[1] = a;
    send_byte(8'h11, a); am[2] = a;
    send_byte(8'h22, a); am[3] = a;
    bus_stop();
    check("R10 ack", {26'd0, am}, 32'h0F);
    check("R10 fb", {16'd0, fb_q}, 32'h1122);
    check("R11 released", {31'd0, sda_oe}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    runs++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule